// File: doc/BRIEF.md
# Compound-Adder Rounding Selector

This block adds two aligned significands and rounds the sum in the same pass. It has no adder followed by a separate incrementer. One parallel-prefix carry network produces the group generate and group propagate terms. From those terms the block forms the plain sum (carry-in 0) and the sum plus one (carry-in 1) side by side. A small decision function looks at the rounding mode, the result sign, the guard, round and sticky bits and the least significant bit of the plain sum. It then steers a multiplexer to one of the two precomputed results.

The block is purely combinational. The upstream stage aligns the operands and supplies the three bits that were shifted out below the result LSB. The downstream stage uses `carry_out` to renormalize and `inexact` to raise the inexact exception. Exponent handling, alignment and normalization belong to the neighbouring stages.

Top module: `rnd_select_add`

## Requirements
- R1: With no increment chosen, `{carry_out, rounded}` equals the (N+1)-bit value `op_a + op_b`.
- R2: With an increment chosen, `{carry_out, rounded}` equals `op_a + op_b + 1`, taken from the same carry network with carry-in 1.
- R3: Mode 2'b00 (nearest, ties to even) increments when the guard bit is 1 and at least one of these is 1: the LSB of `op_a + op_b`, the round bit, the sticky bit.
- R4: An exact halfway case (guard 1, round 0, sticky 0) in mode 2'b00 increments only when the LSB of the sum is 1, so the result LSB ends at 0.
- R5: Mode 2'b01 (toward zero) never increments, for any guard, round, sticky and sign.
- R6: Mode 2'b10 (toward +infinity) increments when `sign_neg` is 0 and any of guard, round, sticky is 1. When `sign_neg` is 1 it truncates.
- R7: Mode 2'b11 (toward -infinity) increments when `sign_neg` is 1 and any of guard, round, sticky is 1. When `sign_neg` is 0 it truncates.
- R8: `inexact` is the OR of guard, round and sticky in every mode. When all three are 0, no mode increments.
- R9: When the plain sum is all ones in N bits with no carry and an increment is chosen, `rounded` wraps to zero and `carry_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First aligned significand |
| op_b | input | N | Second aligned significand |
| guard_bit | input | 1 | First bit below the result LSB |
| round_bit | input | 1 | Second bit below the result LSB |
| sticky_bit | input | 1 | OR of all lower discarded bits |
| sign_neg | input | 1 | Result sign, 1 for negative |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| rounded | output | N | Selected rounded significand |
| carry_out | output | 1 | Carry out of the selected result |
| inexact | output | 1 | Discarded bits were nonzero |

## Verification
Two functions can land in the same cycle: the rounding increment and the carry out of the significand add. The increment can also ripple through an all-ones sum into that same carry. The bench provokes this with operand pairs whose sum is exactly 2^N-1, and with pairs that already carry out while guard and sticky request an increment. It judges each case against (N+1)-bit sums that it computes itself, checking that wrapped zero, carry and inexact all agree. The halfway ties and the sign-dependent directed modes are swept on the same operands, so the mode-dependent selection is the only thing that changes between checks.

// File: rtl/rnd_sel_pkg.sv
package rnd_sel_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_ZERO      = 2'b01,
    RND_UP        = 2'b10,
    RND_DOWN      = 2'b11
  } rnd_mode_e;

  // Decide whether the rounded value is the sum plus one.
  function automatic logic pick_increment(input rnd_mode_e mode,
                                          input logic      neg,
                                          input logic      lsb,
                                          input logic      g,
                                          input logic      r,
                                          input logic      s);
    logic lost;
    lost = g | r | s;
    case (mode)
      RND_NEAR_EVEN: return g & (lsb | r | s);
      RND_ZERO:      return 1'b0;
      RND_UP:        return ~neg & lost;
      default:       return neg & lost;
    endcase
  endfunction

endpackage

// File: rtl/rnd_prefix_dual_adder.sv
module rnd_prefix_dual_adder #(
  parameter int N = 24
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] sum0,
  output logic [N-1:0] sum1,
  output logic         cout0,
  output logic         cout1
);

  logic [N-1:0] gen_bit, prop_bit;
  logic [N-1:0] grp_g, grp_p;
  logic [N-1:0] carry0, carry1;

  // Prefix network: grp_g[i] / grp_p[i] cover bits i..0.
  function automatic void prefix_tree(input  logic [N-1:0] g_in,
                                      input  logic [N-1:0] p_in,
                                      output logic [N-1:0] g_out,
                                      output logic [N-1:0] p_out);
    logic [N-1:0] gc, pc, gn, pn;
    gc = g_in;
    pc = p_in;
    for (int d = 1; d < N; d = d * 2) begin
      gn = gc;
      pn = pc;
      for (int i = d; i < N; i++) begin
        gn[i] = gc[i] | (pc[i] & gc[i-d]);
        pn[i] = pc[i] & pc[i-d];
      end
      gc = gn;
      pc = pn;
    end
    g_out = gc;
    p_out = pc;
  endfunction

  assign gen_bit  = a & b;
  assign prop_bit = a ^ b;

  always_comb prefix_tree(gen_bit, prop_bit, grp_g, grp_p);

  // Carry into bit i for carry-in 0 and carry-in 1 from one tree.
  generate
    if (N > 1) begin : g_carry_wide
      assign carry0 = {grp_g[N-2:0], 1'b0};
      assign carry1 = {grp_g[N-2:0] | grp_p[N-2:0], 1'b1};
    end else begin : g_carry_narrow
      assign carry0 = 1'b0;
      assign carry1 = 1'b1;
    end
  endgenerate

  assign sum0  = prop_bit ^ carry0;
  assign sum1  = prop_bit ^ carry1;
  assign cout0 = grp_g[N-1];
  assign cout1 = grp_g[N-1] | grp_p[N-1];

  // R2: the carry-in-1 path is exactly one above the carry-in-0 path
  always_comb begin
    assert_plus_one_R2: assert ({cout1, sum1} == {cout0, sum0} + {{N{1'b0}}, 1'b1});
  end

endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_sel_pkg::*;
(
  input  logic [1:0] mode_raw,
  input  logic       neg,
  input  logic       lsb,
  input  logic       g,
  input  logic       r,
  input  logic       s,
  output logic       take_inc,
  output logic       lost_bits
);

  rnd_mode_e mode;

  assign mode      = rnd_mode_e'(mode_raw);
  assign take_inc  = pick_increment(mode, neg, lsb, g, r, s);
  assign lost_bits = g | r | s;

  always_comb begin
    // R5: toward zero never rounds up
    assert_rz_truncates_R5: assert (!(mode == RND_ZERO && take_inc));
    // R8: nothing discarded, nothing added
    assert_exact_no_inc_R8: assert (!(!lost_bits && take_inc));
    // R3: nearest-even increments only with the guard bit set
    assert_near_guard_R3: assert (!(mode == RND_NEAR_EVEN && take_inc && !g));
    // R4: exact tie on an even LSB stays put
    assert_tie_even_R4: assert (!(mode == RND_NEAR_EVEN && g && !r && !s && !lsb && take_inc));
    // R6: toward +inf on a negative result truncates
    assert_up_neg_R6: assert (!(mode == RND_UP && neg && take_inc));
    // R7: toward -inf on a positive result truncates
    assert_down_pos_R7: assert (!(mode == RND_DOWN && !neg && take_inc));
  end

endmodule

// File: rtl/rnd_select_add.sv
module rnd_select_add #(
  parameter int N = 24
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic         guard_bit,
  input  logic         round_bit,
  input  logic         sticky_bit,
  input  logic         sign_neg,
  input  logic [1:0]   rnd_mode,
  output logic [N-1:0] rounded,
  output logic         carry_out,
  output logic         inexact
);

  logic [N-1:0] sum_plain, sum_inc;
  logic         co_plain, co_inc;
  logic         take_inc;

  rnd_prefix_dual_adder #(.N(N)) u_add (
    .a     (op_a),
    .b     (op_b),
    .sum0  (sum_plain),
    .sum1  (sum_inc),
    .cout0 (co_plain),
    .cout1 (co_inc)
  );

  rnd_decide u_dec (
    .mode_raw  (rnd_mode),
    .neg       (sign_neg),
    .lsb       (sum_plain[0]),
    .g         (guard_bit),
    .r         (round_bit),
    .s         (sticky_bit),
    .take_inc  (take_inc),
    .lost_bits (inexact)
  );

  assign rounded   = take_inc ? sum_inc : sum_plain;
  assign carry_out = take_inc ? co_inc  : co_plain;

  always_comb begin
    // R9: incrementing an all-ones sum wraps to zero with a carry
    assert_wrap_carry_R9: assert (!(take_inc && !co_plain && (&sum_plain)) ||
                                  (carry_out && rounded == '0));
    // R1: a carry out of the plain sum survives truncation
    assert_keep_carry_R1: assert (!(!take_inc && co_plain) || carry_out);
  end

endmodule

// File: tb/tb_rnd_select_add.sv
module tb_rnd_select_add;

  localparam int N       = 24;
  localparam int CLK_PER = 10;

  logic         clk = 1'b0;
  logic [N-1:0] op_a, op_b;
  logic         guard_bit, round_bit, sticky_bit, sign_neg;
  logic [1:0]   rnd_mode;
  logic [N-1:0] rounded;
  logic         carry_out, inexact;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;
  logic [31:0] seed = 32'h1F2E3D4C;

  rnd_select_add #(.N(N)) dut (
    .op_a(op_a), .op_b(op_b),
    .guard_bit(guard_bit), .round_bit(round_bit), .sticky_bit(sticky_bit),
    .sign_neg(sign_neg), .rnd_mode(rnd_mode),
    .rounded(rounded), .carry_out(carry_out), .inexact(inexact)
  );

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [N-1:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[N-1:0];
  endfunction

  // Independent reference: round-up decision by a table on {g,r,s}.
  function automatic logic model_up(input logic [1:0] m, input logic neg,
                                    input logic lsb, input logic [2:0] grs);
    if (m == 2'b00) begin
      if (grs > 3'b100)  return 1'b1;
      if (grs == 3'b100) return lsb;
      return 1'b0;
    end
    if (m == 2'b01) return 1'b0;
    if (m == 2'b10) return (grs != 3'b000) && !neg;
    return (grs != 3'b000) && neg;
  endfunction

  task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b,
                       input logic [2:0] grs, input logic neg,
                       input logic [1:0] m, input string tag);
    logic [N:0] base, want;
    logic       up;
    @(posedge clk);
    op_a = a; op_b = b;
    {guard_bit, round_bit, sticky_bit} = grs;
    sign_neg = neg; rnd_mode = m;
    base = {1'b0, a} + {1'b0, b};
    up   = model_up(m, neg, base[0], grs);
    want = base + {{N{1'b0}}, up};
    @(negedge clk);
    n_checks++;
    if ({carry_out, rounded} !== want) begin
      n_fails++;
      $display("FAIL %s: {carry,rounded} got %h expected %h (a=%h b=%h grs=%b neg=%b mode=%b)",
               tag, {carry_out, rounded}, want, a, b, grs, neg, m);
    end
    n_checks++;
    if (inexact !== (grs != 3'b000)) begin
      n_fails++;
      $display("FAIL R8 (%s): inexact got %b expected %b", tag, inexact, grs != 3'b000);
    end
  endtask

  task automatic t_reset_state();
    // all-zero inputs behave as the idle state
    apply('0, '0, 3'b000, 1'b0, 2'b00, "R1");
  endtask

  task automatic t_nearest();
    for (int k = 0; k < 40; k++) begin
      logic [N-1:0] a, b;
      a = next_rand(); b = next_rand();
      for (int grs = 0; grs < 8; grs++) apply(a, b, grs[2:0], k[0], 2'b00, "R3");
    end
    // halfway ties on even and odd sums
    apply(24'h000010, 24'h000002, 3'b100, 1'b0, 2'b00, "R4");
    apply(24'h000010, 24'h000003, 3'b100, 1'b0, 2'b00, "R4");
    apply(24'h7FFFFE, 24'h000001, 3'b100, 1'b1, 2'b00, "R4");
  endtask

  task automatic t_toward_zero();
    for (int k = 0; k < 30; k++) begin
      logic [N-1:0] a, b;
      a = next_rand(); b = next_rand();
      for (int grs = 0; grs < 8; grs++) apply(a, b, grs[2:0], k[1], 2'b01, "R5");
    end
  endtask

  task automatic t_directed();
    for (int k = 0; k < 30; k++) begin
      logic [N-1:0] a, b;
      a = next_rand(); b = next_rand();
      for (int grs = 0; grs < 8; grs++) begin
        apply(a, b, grs[2:0], 1'b0, 2'b10, "R6");
        apply(a, b, grs[2:0], 1'b1, 2'b10, "R6");
        apply(a, b, grs[2:0], 1'b0, 2'b11, "R7");
        apply(a, b, grs[2:0], 1'b1, 2'b11, "R7");
      end
    end
  endtask

  task automatic t_carry_wrap();
    // sum exactly all ones, increment ripples into the carry
    apply(24'hFFFFFF, 24'h000000, 3'b110, 1'b0, 2'b00, "R9");
    apply(24'hF0F0F0, 24'h0F0F0F, 3'b001, 1'b0, 2'b10, "R9");
    apply(24'h800000, 24'h7FFFFF, 3'b010, 1'b1, 2'b11, "R9");
    // plain sum already carries and increment also applies
    apply(24'hFFFFFF, 24'hFFFFFF, 3'b101, 1'b0, 2'b00, "R2");
    apply(24'h900000, 24'h900001, 3'b001, 1'b1, 2'b11, "R2");
    // already carrying, truncated
    apply(24'hC00000, 24'h400000, 3'b111, 1'b0, 2'b01, "R1");
  endtask

  initial begin
    op_a = '0; op_b = '0; guard_bit = 0; round_bit = 0; sticky_bit = 0;
    sign_neg = 0; rnd_mode = 2'b00;
    t_reset_state();
    t_nearest();
    t_toward_zero();
    t_directed();
    t_carry_wrap();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule